// File: doc/BRIEF.md
# Reference Divider Path with Edge-Doubling Mode

This block turns a slow reference input into the strobe that feeds a phase detector. A fast system clock oversamples the reference input through a two-flop synchronizer, and the block detects its edges digitally. In normal mode only falling edges count as events. In doubling mode both rising and falling edges count, which doubles the event rate. A 5-bit counter divides the events by a programmable ratio from 1 to 32. An optional half-rate stage then toggles on every counter wrap, which gives a 50% duty-cycle level at half the rate.

Configuration arrives as a 32-bit word on a one-cycle write port. The word is taken only when its low three bits carry the selector code for this register. Any reserved bit written as 1 raises a sticky error flag. The output stage is a two-state machine with the states `HALF_LOW` and `HALF_HIGH`. Its transitions are:

- `lo_to_hi`: a wrap while half-rate mode is on.
- `hi_to_lo`: a wrap while in `HALF_HIGH`.
- `clear`: an accepted write, which returns the machine to `HALF_LOW` from either state.

Top module: `refdiv_path`

## Requirements
- R1: A write is accepted only when `cfg_data[2:0]` equals 3'b010. A write with any other value leaves the configuration, the error flag, the counter and the half-rate state unchanged.
- R2: The ratio field is `cfg_data[19:15]`. A value from 1 to 31 gives one wrap per that many events, and the value 0 gives one wrap per 32 events.
- R3: With the doubling bit (`cfg_data[20]`) at 0, only falling edges of `ref_in` count as events.
- R4: With the doubling bit at 1, both rising and falling edges of `ref_in` count as events.
- R5: Let edge k be the first clock edge that samples a new `ref_in` value. If the resulting event completes a wrap, `ref_strobe` is high in the cycle after edge k+2. In direct mode `ref_strobe` is high for one clock per wrap and `ref_level` stays 0.
- R6: With the half-rate bit (`cfg_data[21]`) at 1, `ref_level` toggles on every wrap. `ref_strobe` pulses only on the wraps that raise `ref_level` from 0 to 1.
- R7: An accepted write with any 1 outside bits [2:0] and [21:15] sets `cfg_err`. The flag stays at 1 until reset. The fields of that write are still applied.
- R8: An accepted write clears the counter and the half-rate state. An event that falls in the same cycle as the write is dropped.
- R9: A synchronous active-high `rst` clears `ref_strobe`, `ref_level` and `cfg_err`. It also sets doubling off, half-rate off and a ratio of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the reference |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Asynchronous reference input |
| cfg_we | input | 1 | One-cycle write strobe for the configuration word |
| cfg_data | input | 32 | Configuration word |
| ref_strobe | output | 1 | One-cycle reference strobe to the phase detector |
| ref_level | output | 1 | Half-rate toggle level (50% duty cycle) |
| cfg_err | output | 1 | Sticky flag: a reserved bit was written as 1 |

## Verification
Two functions can fall on the same clock edge: an accepted configuration write, and a synchronized reference edge that would advance or wrap the counter. The bench provokes the collision directly. It changes `ref_in`, then asserts `cfg_we` so that the write is sampled on the edge where the event would count. Randomized writes among random reference toggling make further collisions. A cycle-level model built from the requirements judges the outcome. The write must win, so the bench expects no strobe, a cleared phase, and a count that starts afresh from the next event.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
    localparam int CFG_W      = 32;
    localparam int RATIO_W    = 5;
    localparam int SEL_W      = 3;
    localparam logic [SEL_W-1:0] SEL_CODE = 3'b010;
    localparam int RATIO_LSB  = 15;
    localparam int DBL_BIT    = 20;
    localparam int HALF_BIT   = 21;
    localparam logic [CFG_W-1:0] USED_MASK =
        ((CFG_W'(1) << SEL_W) - CFG_W'(1)) |
        (((CFG_W'(1) << RATIO_W) - CFG_W'(1)) << RATIO_LSB) |
        (CFG_W'(1) << DBL_BIT) | (CFG_W'(1) << HALF_BIT);

    typedef struct packed {
        logic               half;
        logic               dbl;
        logic [RATIO_W-1:0] ratio;
    } refdiv_cfg_t;

    typedef enum logic [0:0] {
        HALF_LOW  = 1'b0,
        HALF_HIGH = 1'b1
    } half_state_t;
endpackage

// File: rtl/refdiv_cfg.sv
module refdiv_cfg
    import refdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output refdiv_cfg_t      cfg,
    output logic             load,
    output logic             err
);
    logic bad_bits;

    assign load     = wr_en && (wr_data[SEL_W-1:0] == SEL_CODE);
    assign bad_bits = |(wr_data & ~USED_MASK);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.half  <= 1'b0;
            cfg.dbl   <= 1'b0;
            cfg.ratio <= RATIO_W'(1);
            err       <= 1'b0;
        end else if (load) begin
            cfg.half  <= wr_data[HALF_BIT];
            cfg.dbl   <= wr_data[DBL_BIT];
            cfg.ratio <= wr_data[RATIO_LSB +: RATIO_W];
            err       <= err | bad_bits;
        end
    end

    // R1
    ignored_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[SEL_W-1:0] != SEL_CODE) |=> ($stable(cfg) && $stable(err)));
    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err |=> err);
endmodule

// File: rtl/refdiv_edge.sv
module refdiv_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_in,
    input  logic dbl,
    output logic evt
);
    localparam int LAST = SYNC_STAGES;

    logic [LAST:0] sh;
    logic          fall_e;
    logic          any_e;

    generate
        for (genvar g = 0; g <= LAST; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sh[g] <= 1'b0;
                    else     sh[g] <= ref_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) sh[g] <= 1'b0;
                    else     sh[g] <= sh[g-1];
                end
            end
        end
    endgenerate

    assign fall_e = sh[LAST] & ~sh[LAST-1];
    assign any_e  = sh[LAST] ^  sh[LAST-1];
    assign evt    = dbl ? any_e : fall_e;

    // R3
    fall_only_chk: assert property (@(posedge clk) disable iff (rst)
        (evt && !dbl) |-> !sh[LAST-1]);
endmodule

// File: rtl/refdiv_count.sv
module refdiv_count #(
    parameter int RATIO_W = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               evt,
    input  logic [RATIO_W-1:0] ratio,
    output logic               wrap
);
    logic [RATIO_W-1:0] cnt;
    logic [RATIO_W-1:0] term;

    assign term = ratio - RATIO_W'(1);
    assign wrap = evt && !clr && (cnt == term);

    always_ff @(posedge clk) begin
        if (rst || clr)     cnt <= '0;
        else if (evt) begin
            if (cnt == term) cnt <= '0;
            else             cnt <= cnt + RATIO_W'(1);
        end
    end

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= term);
    // R8
    clear_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0));
endmodule

// File: rtl/refdiv_out.sv
module refdiv_out
    import refdiv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic half,
    input  logic wrap,
    output logic strobe,
    output logic level
);
    half_state_t state, nxt;
    logic        strobe_d;

    always_ff @(posedge clk) begin
        if (rst) state <= HALF_LOW;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            HALF_LOW:  if (half && wrap) nxt = HALF_HIGH;
            HALF_HIGH: if (wrap)         nxt = HALF_LOW;
            default:                     nxt = HALF_LOW;
        endcase
        if (clr) nxt = HALF_LOW;
    end

    always_comb begin
        if (clr)       strobe_d = 1'b0;
        else if (half) strobe_d = wrap && (state == HALF_LOW);
        else           strobe_d = wrap;
    end

    always_ff @(posedge clk) begin
        if (rst) strobe <= 1'b0;
        else     strobe <= strobe_d;
    end

    assign level = (state == HALF_HIGH);

    // R6
    half_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe && half) |-> level);
    // R5
    direct_level_chk: assert property (@(posedge clk) disable iff (rst)
        !half |-> !level);
    // R8
    clear_phase_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (!level && !strobe));
endmodule

// File: rtl/refdiv_path.sv
module refdiv_path
    import refdiv_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_in,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_data,
    output logic             ref_strobe,
    output logic             ref_level,
    output logic             cfg_err
);
    refdiv_cfg_t cfg;
    logic        load;
    logic        evt;
    logic        wrap;

    refdiv_cfg u_cfg (
        .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_data(cfg_data),
        .cfg(cfg), .load(load), .err(cfg_err)
    );

    refdiv_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst(rst), .ref_in(ref_in), .dbl(cfg.dbl), .evt(evt)
    );

    refdiv_count #(.RATIO_W(RATIO_W)) u_count (
        .clk(clk), .rst(rst), .clr(load), .evt(evt),
        .ratio(cfg.ratio), .wrap(wrap)
    );

    refdiv_out u_out (
        .clk(clk), .rst(rst), .clr(load), .half(cfg.half), .wrap(wrap),
        .strobe(ref_strobe), .level(ref_level)
    );
endmodule

// File: tb/refdiv_path_bench.sv
module refdiv_path_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_in = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_data = '0;
    logic        ref_strobe, ref_level, cfg_err;

    int    checks = 0;
    int    fails  = 0;
    int    strobe_seen = 0;
    bit    done = 1'b0;
    string cur_req = "R9";

    always #(CLK_PERIOD/2) clk = ~clk;

    refdiv_path u_refdiv_path (
        .clk(clk), .rst(rst), .ref_in(ref_in), .cfg_we(cfg_we),
        .cfg_data(cfg_data), .ref_strobe(ref_strobe),
        .ref_level(ref_level), .cfg_err(cfg_err)
    );

    // reference model built from the requirements
    logic       m_s1, m_s2, m_s3;
    logic [4:0] m_ratio;
    logic       m_dbl, m_half, m_err, m_tog, m_strobe;
    int         m_cnt;

    function automatic int div_of(input logic [4:0] r);
        return (r == 5'd0) ? 32 : int'(r);
    endfunction

    function automatic logic is_event(input logic prev, input logic cur, input logic d);
        return d ? (prev != cur) : (prev && !cur);
    endfunction

    function automatic logic [31:0] mk_cfg(input logic [2:0] sel, input logic [4:0] r,
                                           input logic d, input logic h);
        logic [31:0] w;
        w = '0;
        w[2:0]   = sel;
        w[19:15] = r;
        w[20]    = d;
        w[21]    = h;
        return w;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_s1 <= 0; m_s2 <= 0; m_s3 <= 0;
            m_ratio <= 5'd1; m_dbl <= 0; m_half <= 0; m_err <= 0;
            m_tog <= 0; m_strobe <= 0; m_cnt <= 0;
        end else begin
            m_s1 <= ref_in; m_s2 <= m_s1; m_s3 <= m_s2;
            if (cfg_we && cfg_data[2:0] == 3'b010) begin
                m_ratio <= cfg_data[19:15];
                m_dbl   <= cfg_data[20];
                m_half  <= cfg_data[21];
                if ((cfg_data & ~32'h003F_8007) != 0) m_err <= 1'b1;
                m_cnt <= 0; m_tog <= 0; m_strobe <= 0;
            end else if (is_event(m_s3, m_s2, m_dbl)) begin
                if (m_cnt + 1 == div_of(m_ratio)) begin
                    m_cnt <= 0;
                    if (m_half) begin
                        m_tog    <= !m_tog;
                        m_strobe <= !m_tog;
                    end else begin
                        m_strobe <= 1'b1;
                    end
                end else begin
                    m_cnt    <= m_cnt + 1;
                    m_strobe <= 1'b0;
                end
            end else begin
                m_strobe <= 1'b0;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            checks += 3;
            if (ref_strobe !== m_strobe) begin
                fails++;
                $display("FAIL %s R5 ref_strobe act=%0b exp=%0b t=%0t", cur_req, ref_strobe, m_strobe, $time);
            end
            if (ref_level !== m_tog) begin
                fails++;
                $display("FAIL %s R6 ref_level act=%0b exp=%0b t=%0t", cur_req, ref_level, m_tog, $time);
            end
            if (cfg_err !== m_err) begin
                fails++;
                $display("FAIL %s R7 cfg_err act=%0b exp=%0b t=%0t", cur_req, cfg_err, m_err, $time);
            end
            if (ref_strobe === 1'b1) strobe_seen++;
        end
    end

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [31:0] w);
        @(negedge clk); cfg_we = 1'b1; cfg_data = w;
        @(negedge clk); cfg_we = 1'b0; cfg_data = '0;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // n full reference periods with given high/low lengths
    task automatic ref_periods(input int n, input int hi, input int lo);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ref_in = 1'b1; wait_cyc(hi - 1);
            @(negedge clk); ref_in = 1'b0; wait_cyc(lo - 1);
        end
    endtask

    task automatic do_reset;
        @(negedge clk); rst = 1'b1; ref_in = 1'b0; cfg_we = 1'b0;
        wait_cyc(3);
        rst = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd7741));
        wait_cyc(3);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        check_eq("R9 strobe after reset", int'(ref_strobe), 0);
        check_eq("R9 level after reset", int'(ref_level), 0);
        check_eq("R9 err after reset", int'(cfg_err), 0);

        // R9 / R3: default ratio 1, falling edges only
        cur_req = "R9"; strobe_seen = 0;
        ref_periods(6, 3, 3); wait_cyc(6);
        check_eq("R9 R3 default ratio strobes", strobe_seen, 6);

        // R2 / R3: ratio 5, falling only
        cur_req = "R2"; write_cfg(mk_cfg(3'b010, 5'd5, 1'b0, 1'b0));
        strobe_seen = 0; ref_periods(20, 2, 3); wait_cyc(6);
        check_eq("R2 ratio5 strobes", strobe_seen, 4);

        // R4: doubling with ratio 4
        cur_req = "R4"; write_cfg(mk_cfg(3'b010, 5'd4, 1'b1, 1'b0));
        strobe_seen = 0; ref_periods(10, 3, 2); wait_cyc(6);
        check_eq("R4 doubled strobes", strobe_seen, 5);

        // R2: ratio field 0 means 32, doubled
        cur_req = "R2"; write_cfg(mk_cfg(3'b010, 5'd0, 1'b1, 1'b0));
        strobe_seen = 0; ref_periods(32, 1, 1); wait_cyc(6);
        check_eq("R2 ratio32 strobes", strobe_seen, 2);

        // R6: half-rate with ratio 3
        cur_req = "R6"; write_cfg(mk_cfg(3'b010, 5'd3, 1'b0, 1'b1));
        strobe_seen = 0; ref_periods(12, 2, 2); wait_cyc(6);
        check_eq("R6 half-rate strobes", strobe_seen, 2);
        check_eq("R6 level after even wraps", int'(ref_level), 0);

        // R1: ignored write keeps ratio 3 half-rate
        cur_req = "R1"; ref_periods(3, 2, 2); wait_cyc(5);
        write_cfg(mk_cfg(3'b011, 5'd1, 1'b1, 1'b0) | 32'h8000_0000);
        check_eq("R1 level kept after ignored write", int'(ref_level), 1);
        check_eq("R1 err kept after ignored write", int'(cfg_err), 0);
        strobe_seen = 0; ref_periods(9, 2, 2); wait_cyc(6);
        check_eq("R1 old ratio still used", strobe_seen, 1);

        // R8: write coinciding with an event
        cur_req = "R8"; write_cfg(mk_cfg(3'b010, 5'd1, 1'b0, 1'b0));
        @(negedge clk); ref_in = 1'b1; wait_cyc(4);
        strobe_seen = 0;
        @(negedge clk); ref_in = 1'b0;
        @(negedge clk);
        @(negedge clk); cfg_we = 1'b1; cfg_data = mk_cfg(3'b010, 5'd1, 1'b0, 1'b0);
        @(negedge clk); cfg_we = 1'b0; cfg_data = '0;
        wait_cyc(5);
        check_eq("R8 event dropped on write", strobe_seen, 0);
        // R5: latency of three edges
        @(negedge clk); ref_in = 1'b1; wait_cyc(3);
        @(negedge clk); ref_in = 1'b0;
        @(negedge clk); check_eq("R5 no strobe after 1 edge", int'(ref_strobe), 0);
        @(negedge clk); check_eq("R5 no strobe after 2 edges", int'(ref_strobe), 0);
        @(negedge clk); check_eq("R5 strobe after 3 edges", int'(ref_strobe), 1);
        @(negedge clk); check_eq("R5 strobe one cycle", int'(ref_strobe), 0);

        // R7: reserved bit sets sticky error, fields applied
        cur_req = "R7"; write_cfg(mk_cfg(3'b010, 5'd2, 1'b0, 1'b0) | 32'h0000_0100);
        check_eq("R7 err set", int'(cfg_err), 1);
        strobe_seen = 0; ref_periods(6, 2, 2); wait_cyc(6);
        check_eq("R7 fields applied", strobe_seen, 3);
        write_cfg(mk_cfg(3'b010, 5'd2, 1'b0, 1'b0));
        check_eq("R7 err sticky", int'(cfg_err), 1);
        cur_req = "R9"; do_reset; @(negedge clk);
        check_eq("R9 err cleared by reset", int'(cfg_err), 0);

        // random mix, model-checked every cycle
        cur_req = "R8";
        for (int k = 0; k < 40; k++) begin
            logic [31:0] w;
            w = mk_cfg(($urandom % 4 == 0) ? 3'($urandom) : 3'b010,
                       5'($urandom), 1'($urandom), 1'($urandom));
            if ($urandom % 8 == 0) w[31] = 1'b1;
            @(negedge clk); cfg_we = 1'b1; cfg_data = w;
            @(negedge clk); cfg_we = 1'b0; cfg_data = '0;
            for (int j = 0; j < 50; j++) begin
                @(negedge clk);
                if ($urandom % 3 == 0) ref_in = ~ref_in;
                if ($urandom % 40 == 0) begin
                    cfg_we = 1'b1; cfg_data = mk_cfg(3'b010, 5'($urandom), 1'($urandom), 1'($urandom));
                    @(negedge clk); cfg_we = 1'b0; cfg_data = '0;
                end
            end
        end
        wait_cyc(6);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1'b1;
            fails++; checks++;
            $display("FAIL watchdog expired in %s", cur_req);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule